// File: doc/BRIEF.md
# Out-of-order issue window with tag wakeup and oldest-first select

This block is the scheduling heart of an out-of-order core. Renamed instructions enter a centralized window of `DEPTH` slots, each holding a left and a right source tag with a ready flag per operand, a destination tag and an opaque instruction identifier. Every cycle a set of result tags is broadcast to all slots at once. Each slot compares every broadcast tag against both of its source tags, and any hit marks that operand ready.

A slot whose two operands are both ready raises a request. A chain of request/grant trees with fan-in 4 picks up to `LANES` requesters per cycle, oldest first, one per functional-unit lane. Granted slots are freed at once. Their destination tags join the broadcast in the same cycle, so a dependent instruction issues in the very next cycle.

Producers outside the window, such as long-latency loads, use the external broadcast port, which has one tag lane per issue lane. A dispatch is accepted only while a slot is free.

Top module: `iw_sched_top`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `disp_ready` is 1 and every `iss_valid` bit is 0.
- R2: A dispatch is taken when `disp_valid` and `disp_ready` are both high in a cycle. `disp_ready` is low exactly when all `DEPTH` slots hold instructions, and a dispatch offered while it is low is dropped.
- R3: A held instruction's left or right operand becomes ready at the clock edge where any external broadcast lane k (`bc_valid[k]` = 1) carries a tag equal to that operand's source tag.
- R4: An instruction with only one ready operand is never issued.
- R5: A dispatched operand enters ready if its ready input is 1, or if its tag equals a valid external broadcast or a destination tag granted in the same cycle.
- R6: At most `LANES` instructions are issued per cycle, and each dispatched instruction is issued exactly once.
- R7: Among instructions whose operands are all ready, lane 0 receives the oldest by dispatch order, lane 1 the next oldest, and so on. Lanes fill from lane 0 upward with no gap.
- R8: An instruction granted in cycle t wakes its dependents at the end of cycle t, so a dependent issued directly behind it appears on the outputs one cycle after the producer.
- R9: Issue outputs are registered. An instruction dispatched in cycle c with both operands ready, and selected, is shown on `iss_valid`/`iss_id`/`iss_dtag` in cycle c+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| disp_valid | input | 1 | Dispatch offer this cycle |
| disp_ready | output | 1 | At least one slot is free |
| disp_ltag | input | TAG_W | Left source tag |
| disp_lrdy | input | 1 | Left operand already available |
| disp_rtag | input | TAG_W | Right source tag |
| disp_rrdy | input | 1 | Right operand already available |
| disp_dtag | input | TAG_W | Destination tag |
| disp_id | input | ID_W | Opaque instruction identifier |
| bc_valid | input | LANES | Per-lane external broadcast valid |
| bc_tag | input | LANES×TAG_W | Per-lane external broadcast tag |
| iss_valid | output | LANES | Per-lane issue valid |
| iss_id | output | LANES×ID_W | Identifier of the issued instruction |
| iss_dtag | output | LANES×TAG_W | Destination tag of the issued instruction |

## Verification
The assertions assume that reset is held for at least two edges. They also assume that the window never holds more than 2^(SEQ_W-1) dispatches between its oldest and newest live entry, because the modular age compare is only valid within that span. The bench resets for four cycles and runs far fewer than 32768 dispatches in total, so this bound cannot be reached. Identifiers are issued from a counter, so they are unique inside the window, and each lane's issue can be matched against the bench's in-order model. Broadcast tags are drawn from a small range in the random phase, so multi-lane and same-cycle matches occur often.

// File: rtl/iw_pkg.sv
package iw_pkg;
  parameter int IW_DEPTH  = 8;
  parameter int IW_TAG_W  = 6;
  parameter int IW_ID_W   = 8;
  parameter int IW_LANES  = 2;
  parameter int IW_SEQ_W  = 16;
  parameter int IW_FANIN  = 4;

  // number of tree levels needed to cover n leaves with the given fan-in
  function automatic int tree_levels(input int n, input int f);
    int lv;
    int cap;
    lv  = 0;
    cap = 1;
    for (int i = 0; i < 32; i++) begin
      if (cap < n) begin
        cap = cap * f;
        lv  = lv + 1;
      end
    end
    return (lv == 0) ? 1 : lv;
  endfunction
endpackage

// File: rtl/iw_wakeup_cam.sv
module iw_wakeup_cam #(
  parameter int SLOTS = 8,
  parameter int TAG_W = 6,
  parameter int NWAKE = 4
) (
  input  logic [SLOTS-1:0][TAG_W-1:0] ltag,
  input  logic [SLOTS-1:0][TAG_W-1:0] rtag,
  input  logic [NWAKE-1:0]            wk_vld,
  input  logic [NWAKE-1:0][TAG_W-1:0] wk_tag,
  output logic [SLOTS-1:0]            lhit,
  output logic [SLOTS-1:0]            rhit
);
  for (genvar e = 0; e < SLOTS; e++) begin : g_slot
    logic [NWAKE-1:0] lm;
    logic [NWAKE-1:0] rm;
    for (genvar w = 0; w < NWAKE; w++) begin : g_tag
      assign lm[w] = wk_vld[w] && (wk_tag[w] == ltag[e]);
      assign rm[w] = wk_vld[w] && (wk_tag[w] == rtag[e]);
    end
    assign lhit[e] = |lm;
    assign rhit[e] = |rm;
  end
endmodule

// File: rtl/iw_select_tree.sv
module iw_select_tree #(
  parameter int DEPTH = 8,
  parameter int SEQ_W = 16,
  parameter int FANIN = 4,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0]            req,
  input  logic [DEPTH-1:0][SEQ_W-1:0] seq,
  output logic                        gnt_vld,
  output logic [IDX_W-1:0]            gnt_idx
);
  localparam int LVLS   = iw_pkg::tree_levels(DEPTH, FANIN);
  localparam int LEAVES = FANIN ** LVLS;
  localparam int LW     = $clog2(LEAVES);

  logic             nv [LVLS+1][LEAVES];
  logic [SEQ_W-1:0] ns [LVLS+1][LEAVES];
  logic [LW-1:0]    ni [LVLS+1][LEAVES];
  logic [LEAVES-1:0] req_pad;

  assign req_pad = LEAVES'(req);

  // a is older than b under modular sequence numbers
  function automatic logic older(input logic [SEQ_W-1:0] a, input logic [SEQ_W-1:0] b);
    logic [SEQ_W-1:0] d;
    d = a - b;
    return d[SEQ_W-1];
  endfunction

  always_comb begin
    int cnt;
    int c;
    for (int j = 0; j < LEAVES; j++) begin
      nv[0][j] = req_pad[j];
      ns[0][j] = '0;
      ni[0][j] = LW'(j);
    end
    for (int j = 0; j < DEPTH; j++) ns[0][j] = seq[j];
    cnt = LEAVES;
    for (int l = 0; l < LVLS; l++) begin
      cnt = cnt / FANIN;
      for (int j = 0; j < LEAVES; j++) begin
        nv[l+1][j] = 1'b0;
        ns[l+1][j] = '0;
        ni[l+1][j] = '0;
        if (j < cnt) begin
          for (int k = 0; k < FANIN; k++) begin
            c = j * FANIN + k;
            if (nv[l][c] && (!nv[l+1][j] || older(ns[l][c], ns[l+1][j]))) begin
              nv[l+1][j] = 1'b1;
              ns[l+1][j] = ns[l][c];
              ni[l+1][j] = ni[l][c];
            end
          end
        end
      end
    end
  end

  assign gnt_vld = nv[LVLS][0];
  assign gnt_idx = IDX_W'(ni[LVLS][0]);
endmodule

// File: rtl/iw_sched_top.sv
module iw_sched_top
  import iw_pkg::*;
#(
  parameter int DEPTH = IW_DEPTH,
  parameter int TAG_W = IW_TAG_W,
  parameter int ID_W  = IW_ID_W,
  parameter int LANES = IW_LANES,
  parameter int SEQ_W = IW_SEQ_W,
  parameter int FANIN = IW_FANIN
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       disp_valid,
  output logic                       disp_ready,
  input  logic [TAG_W-1:0]           disp_ltag,
  input  logic                       disp_lrdy,
  input  logic [TAG_W-1:0]           disp_rtag,
  input  logic                       disp_rrdy,
  input  logic [TAG_W-1:0]           disp_dtag,
  input  logic [ID_W-1:0]            disp_id,
  input  logic [LANES-1:0]           bc_valid,
  input  logic [LANES-1:0][TAG_W-1:0] bc_tag,
  output logic [LANES-1:0]           iss_valid,
  output logic [LANES-1:0][ID_W-1:0] iss_id,
  output logic [LANES-1:0][TAG_W-1:0] iss_dtag
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int NWAKE = 2 * LANES;

  // slot state
  logic [DEPTH-1:0]            vld;
  logic [DEPTH-1:0]            lrdy_q;
  logic [DEPTH-1:0]            rrdy_q;
  logic [DEPTH-1:0][TAG_W-1:0] lt;
  logic [DEPTH-1:0][TAG_W-1:0] rt;
  logic [DEPTH-1:0][TAG_W-1:0] dt;
  logic [DEPTH-1:0][ID_W-1:0]  idq;
  logic [DEPTH-1:0][SEQ_W-1:0] sq;
  logic [SEQ_W-1:0]            seq_ctr;

  // select
  logic [DEPTH-1:0]            req;
  logic [LANES:0][DEPTH-1:0]   taken;
  logic [DEPTH-1:0]            gnt;
  logic [LANES-1:0]            sv;
  logic [LANES-1:0][IDX_W-1:0] si;
  logic [LANES-1:0][TAG_W-1:0] gdt;

  // wakeup
  logic [NWAKE-1:0]            wk_vld;
  logic [NWAKE-1:0][TAG_W-1:0] wk_tag;
  logic [DEPTH-1:0]            lhit;
  logic [DEPTH-1:0]            rhit;
  logic [0:0]                  d_lhit;
  logic [0:0]                  d_rhit;

  // dispatch
  logic                        accept;
  logic [IDX_W-1:0]            free_idx;

  assign req      = vld & lrdy_q & rrdy_q;
  assign taken[0] = '0;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    iw_select_tree #(
      .DEPTH(DEPTH),
      .SEQ_W(SEQ_W),
      .FANIN(FANIN)
    ) u_sel (
      .req    (req & ~taken[k]),
      .seq    (sq),
      .gnt_vld(sv[k]),
      .gnt_idx(si[k])
    );
    assign taken[k+1] = taken[k] | (sv[k] ? (DEPTH'(1) << si[k]) : '0);
    assign gdt[k]     = dt[si[k]];
  end

  assign gnt    = taken[LANES];
  assign wk_vld = {sv, bc_valid};
  assign wk_tag = {gdt, bc_tag};

  iw_wakeup_cam #(
    .SLOTS(DEPTH),
    .TAG_W(TAG_W),
    .NWAKE(NWAKE)
  ) u_cam (
    .ltag  (lt),
    .rtag  (rt),
    .wk_vld(wk_vld),
    .wk_tag(wk_tag),
    .lhit  (lhit),
    .rhit  (rhit)
  );

  iw_wakeup_cam #(
    .SLOTS(1),
    .TAG_W(TAG_W),
    .NWAKE(NWAKE)
  ) u_dcam (
    .ltag  (disp_ltag),
    .rtag  (disp_rtag),
    .wk_vld(wk_vld),
    .wk_tag(wk_tag),
    .lhit  (d_lhit),
    .rhit  (d_rhit)
  );

  always_comb begin
    free_idx = '0;
    for (int e = DEPTH - 1; e >= 0; e--) begin
      if (!vld[e]) free_idx = IDX_W'(e);
    end
  end

  assign disp_ready = ~&vld;
  assign accept     = disp_valid && disp_ready;

  // control state with reset
  always_ff @(posedge clk) begin
    if (rst) begin
      vld       <= '0;
      lrdy_q    <= '0;
      rrdy_q    <= '0;
      seq_ctr   <= '0;
      iss_valid <= '0;
    end else begin
      for (int e = 0; e < DEPTH; e++) begin
        if (gnt[e]) begin
          vld[e] <= 1'b0;
        end else if (vld[e]) begin
          if (lhit[e]) lrdy_q[e] <= 1'b1;
          if (rhit[e]) rrdy_q[e] <= 1'b1;
        end
      end
      if (accept) begin
        vld[free_idx]    <= 1'b1;
        lrdy_q[free_idx] <= disp_lrdy | d_lhit[0];
        rrdy_q[free_idx] <= disp_rrdy | d_rhit[0];
        seq_ctr          <= seq_ctr + 1'b1;
      end
      iss_valid <= sv;
    end
  end

  // payload storage, written only on dispatch
  always_ff @(posedge clk) begin
    if (accept) begin
      lt[free_idx]  <= disp_ltag;
      rt[free_idx]  <= disp_rtag;
      dt[free_idx]  <= disp_dtag;
      idq[free_idx] <= disp_id;
      sq[free_idx]  <= seq_ctr;
    end
  end

  // issue payload registers
  always_ff @(posedge clk) begin
    for (int k = 0; k < LANES; k++) begin
      iss_id[k]   <= idq[si[k]];
      iss_dtag[k] <= dt[si[k]];
    end
  end
endmodule

// File: rtl/iw_sched_chk.sv
module iw_sched_chk #(
  parameter int DEPTH = 8,
  parameter int LANES = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             disp_valid,
  input logic             disp_ready,
  input logic [LANES-1:0] iss_valid,
  input logic [DEPTH-1:0] vld,
  input logic [DEPTH-1:0] lrdy_q,
  input logic [DEPTH-1:0] rrdy_q,
  input logic [DEPTH-1:0] gnt
);
  // R2
  full_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (disp_valid && !disp_ready) |=> ($countones(vld) <= $past($countones(vld))));

  // R7
  lane_pack_chk: assert property (@(posedge clk) disable iff (rst)
    ((iss_valid & (iss_valid + LANES'(1))) == '0));

  // R9
  issue_reg_chk: assert property (@(posedge clk) disable iff (rst)
    (!rst) |=> ($countones(iss_valid) == $past($countones(gnt))));

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    // R4
    both_ready_chk: assert property (@(posedge clk) disable iff (rst)
      gnt[e] |-> (vld[e] && lrdy_q[e] && rrdy_q[e]));

    // R6
    free_on_grant_chk: assert property (@(posedge clk) disable iff (rst)
      gnt[e] |=> !vld[e]);

    // R3
    left_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      (vld[e] && lrdy_q[e] && !gnt[e]) |=> lrdy_q[e]);

    // R3
    right_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      (vld[e] && rrdy_q[e] && !gnt[e]) |=> rrdy_q[e]);
  end
endmodule

bind iw_sched_top iw_sched_chk #(
  .DEPTH(DEPTH),
  .LANES(LANES)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .disp_valid(disp_valid),
  .disp_ready(disp_ready),
  .iss_valid (iss_valid),
  .vld       (vld),
  .lrdy_q    (lrdy_q),
  .rrdy_q    (rrdy_q),
  .gnt       (gnt)
);

// File: tb/iw_sched_top_tb_top.sv
module iw_sched_top_tb_top;
  localparam int D   = 8;
  localparam int TW  = 6;
  localparam int IDW = 8;
  localparam int L   = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic                  disp_valid = 1'b0;
  logic                  disp_ready;
  logic [TW-1:0]         disp_ltag = '0;
  logic                  disp_lrdy = 1'b0;
  logic [TW-1:0]         disp_rtag = '0;
  logic                  disp_rrdy = 1'b0;
  logic [TW-1:0]         disp_dtag = '0;
  logic [IDW-1:0]        disp_id = '0;
  logic [L-1:0]          bc_valid = '0;
  logic [L-1:0][TW-1:0]  bc_tag = '0;
  logic [L-1:0]          iss_valid;
  logic [L-1:0][IDW-1:0] iss_id;
  logic [L-1:0][TW-1:0]  iss_dtag;

  iw_sched_top #(
    .DEPTH(D), .TAG_W(TW), .ID_W(IDW), .LANES(L), .SEQ_W(16), .FANIN(4)
  ) dut_i (
    .clk(clk), .rst(rst),
    .disp_valid(disp_valid), .disp_ready(disp_ready),
    .disp_ltag(disp_ltag), .disp_lrdy(disp_lrdy),
    .disp_rtag(disp_rtag), .disp_rrdy(disp_rrdy),
    .disp_dtag(disp_dtag), .disp_id(disp_id),
    .bc_valid(bc_valid), .bc_tag(bc_tag),
    .iss_valid(iss_valid), .iss_id(iss_id), .iss_dtag(iss_dtag)
  );

  typedef struct {
    int id;
    int lt;
    bit lr;
    int rt;
    bit rr;
    int dt;
  } ent_t;

  ent_t  q[$];
  bit    exp_v[L];
  int    exp_id[L];
  int    exp_dt[L];
  bit    exp_rdy = 1'b1;
  int    n_tests = 0;
  int    n_fail  = 0;
  int    next_id = 0;
  string cur_req = "R1";
  bit    done = 1'b0;

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", cur_req, what, act, exp);
    end
  endtask

  // one clock: compare outputs, drive inputs, advance the reference model
  task automatic cycle(input bit dv, input int dlt, input bit dlr, input int drt,
                       input bit drr, input int ddt, input bit [L-1:0] bv,
                       input int bt0, input int bt1);
    int gi[$];
    int wt[$];
    bit acc;
    ent_t n;
    @(negedge clk);
    chk(disp_ready == exp_rdy, "disp_ready", int'(disp_ready), int'(exp_rdy));
    for (int k = 0; k < L; k++) begin
      chk(iss_valid[k] == exp_v[k], $sformatf("iss_valid[%0d]", k), int'(iss_valid[k]), int'(exp_v[k]));
      if (exp_v[k] && iss_valid[k]) begin
        chk(int'(iss_id[k]) == exp_id[k], $sformatf("iss_id[%0d]", k), int'(iss_id[k]), exp_id[k]);
        chk(int'(iss_dtag[k]) == exp_dt[k], $sformatf("iss_dtag[%0d]", k), int'(iss_dtag[k]), exp_dt[k]);
      end
    end
    disp_valid  = dv;
    disp_ltag   = TW'(dlt);
    disp_lrdy   = dlr;
    disp_rtag   = TW'(drt);
    disp_rrdy   = drr;
    disp_dtag   = TW'(ddt);
    disp_id     = IDW'(next_id);
    bc_valid    = bv;
    bc_tag[0]   = TW'(bt0);
    bc_tag[1]   = TW'(bt1);
    acc = dv && (q.size() < D);
    for (int i = 0; i < q.size(); i++)
      if (q[i].lr && q[i].rr && gi.size() < L) gi.push_back(i);
    if (bv[0]) wt.push_back(bt0);
    if (bv[1]) wt.push_back(bt1);
    for (int k = 0; k < L; k++) begin
      exp_v[k] = (k < gi.size());
      exp_id[k] = 0;
      exp_dt[k] = 0;
      if (k < gi.size()) begin
        exp_id[k] = q[gi[k]].id;
        exp_dt[k] = q[gi[k]].dt;
        wt.push_back(q[gi[k]].dt);
      end
    end
    for (int k = gi.size() - 1; k >= 0; k--) q.delete(gi[k]);
    for (int i = 0; i < q.size(); i++)
      foreach (wt[w]) begin
        if (wt[w] == q[i].lt) q[i].lr = 1'b1;
        if (wt[w] == q[i].rt) q[i].rr = 1'b1;
      end
    if (acc) begin
      n.id = next_id % 256;
      n.lt = dlt; n.lr = dlr; n.rt = drt; n.rr = drr; n.dt = ddt;
      foreach (wt[w]) begin
        if (wt[w] == dlt) n.lr = 1'b1;
        if (wt[w] == drt) n.rr = 1'b1;
      end
      q.push_back(n);
      next_id++;
    end
    exp_rdy = (q.size() < D);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cycle(0, 0, 0, 0, 0, 0, 2'b00, 0, 0);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      summary();
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < L; k++) begin exp_v[k] = 0; exp_id[k] = 0; exp_dt[k] = 0; end
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // reset state: window empty, nothing issued
    cur_req = "R1";
    chk(disp_ready == 1'b1, "disp_ready after reset", int'(disp_ready), 1);
    chk(iss_valid == '0, "iss_valid after reset", int'(iss_valid), 0);
    idle(1);

    // fully ready instruction: visible two cycles after its dispatch cycle
    cur_req = "R9";
    cycle(1, 1, 1, 2, 1, 5, 2'b00, 0, 0);
    idle(3);

    // one operand ready only: must stay put
    cur_req = "R4";
    cycle(1, 20, 1, 21, 0, 7, 2'b00, 0, 0);
    idle(4);

    // external broadcast on lane 1 wakes the right operand
    cur_req = "R3";
    cycle(0, 0, 0, 0, 0, 0, 2'b10, 0, 21);
    idle(3);

    // same-cycle broadcast marks the incoming operand ready
    cur_req = "R5";
    cycle(1, 30, 0, 31, 1, 9, 2'b01, 30, 0);
    idle(3);

    // producer grant wakes dependent for back-to-back issue
    cur_req = "R8";
    cycle(1, 50, 0, 51, 1, 41, 2'b00, 0, 0);
    cycle(1, 41, 0, 52, 1, 42, 2'b00, 0, 0);
    cycle(1, 42, 0, 42, 0, 43, 2'b00, 0, 0);
    cycle(0, 0, 0, 0, 0, 0, 2'b01, 50, 0);
    idle(5);

    // fill to capacity, offer while full, then release all
    cur_req = "R2";
    for (int i = 0; i < D + 2; i++) cycle(1, 60, 0, 3, 1, 10 + i, 2'b00, 0, 0);
    chk(disp_ready == 1'b0, "disp_ready when full", int'(disp_ready), 0);
    cur_req = "R7";
    cycle(0, 0, 0, 0, 0, 0, 2'b01, 60, 0);
    idle(6);

    // younger woken first, then the rest together
    cycle(1, 33, 0, 1, 1, 11, 2'b00, 0, 0);
    cycle(1, 34, 0, 1, 1, 12, 2'b00, 0, 0);
    cycle(1, 35, 0, 1, 1, 13, 2'b00, 0, 0);
    cycle(1, 36, 0, 1, 1, 14, 2'b00, 0, 0);
    cycle(0, 0, 0, 0, 0, 0, 2'b01, 36, 0);
    cycle(0, 0, 0, 0, 0, 0, 2'b11, 34, 35);
    cycle(0, 0, 0, 0, 0, 0, 2'b01, 33, 0);
    idle(4);

    // random traffic with a small tag range for dense matches
    cur_req = "R6";
    for (int i = 0; i < 600; i++) begin
      cycle(($urandom_range(0, 9) < 7), $urandom_range(0, 7), $urandom_range(0, 1),
            $urandom_range(0, 7), $urandom_range(0, 1), $urandom_range(0, 7),
            L'($urandom_range(0, 3)), $urandom_range(0, 7), $urandom_range(0, 7));
    end
    for (int t = 0; t < 8; t++) cycle(0, 0, 0, 0, 0, 0, 2'b11, t, t);
    idle(8);
    chk(q.size() == 0, "window drained", q.size(), 0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule